// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external asynchronous 16-bit static RAM with 512K words. Each request carries an address, write data, a write flag and two byte-enable bits. When the controller is idle it accepts the request in a single cycle. It then produces the full pin sequence for the memory: a dual-polarity chip select, write enable, output enable, separate lower and upper byte strobes, the address, and a split data bus made of out, in and drive-enable. A read returns its data together with a one-cycle valid pulse. `busy` stays high from acceptance until the bus is quiet again.

Every phase length is counted in clock cycles. Each count is computed at elaboration as the ceiling of a nanosecond limit divided by the clock period, so a change in clock rate or speed grade only needs new parameter values. Every access is followed by a turnaround gap in which all selects are inactive and the data bus is not driven. This keeps the controller and the memory from ever driving the bus at the same time. Every output pin comes straight from a register, so the strobes cannot glitch.

Top module: `sram_async_ctrl`

## Requirements
- R1: After the synchronous active-low reset, and whenever `busy` is low, `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1, `mem_lo_n`=1, `mem_hi_n`=1 and `mem_dq_drv`=0. After reset, `busy`=0 and `rsp_valid`=0.
- R2: A request is taken only on a rising edge where `req_valid`=1 and `busy`=0. A request presented while `busy` is high is ignored, and the pins keep the values of the access already under way.
- R3: For a read taken at edge E0, the selects and byte strobes are active from E0 to E0+RD_CYC. `mem_rd_n` is low from E0+1 to E0+RD_CYC. `mem_wr_n` stays high and `mem_dq_drv` stays low for the whole read.
- R4: Read data is sampled at edge E0+RD_CYC, and `rsp_valid` is high for exactly the following cycle. Bits 7:0 of `rsp_data` come from the bus only when `req_be[0]`=1, and bits 15:8 only when `req_be[1]`=1. A lane that is not enabled reads as zero.
- R5: For a write taken at E0, `mem_dq_out` holds the write data and `mem_dq_drv`=1 from E0 to E0+WR_CYC. `mem_wr_n` is low for exactly WP_CYC cycles, from E0+1 to E0+1+WP_CYC. `mem_rd_n` stays high throughout.
- R6: Within an access, `mem_lo_n` is low exactly when `req_be[0]`=1, and `mem_hi_n` is low exactly when `req_be[1]`=1. A write changes only the enabled byte lanes of the addressed word.
- R7: Every access is followed by TURN_CYC cycles in which `busy`=1, the selects are inactive and `mem_dq_drv`=0. `busy` falls at edge E0+ACC+TURN_CYC, where ACC is RD_CYC or WR_CYC.
- R8: A request with `req_be`=00 keeps `busy` high for one cycle only. It produces no select, no write or read strobe and no `rsp_valid`, and it leaves memory unchanged.
- R9: The cycle counts are derived from the nanosecond parameters by ceiling division: RD_CYC = max(ceil(tRC), ceil(tAA), 1+ceil(tOE)), WP_CYC = max(ceil(tWP), ceil(tCW)-1, ceil(tDW)-1), WR_CYC = max(ceil(tWC), WP_CYC+1), TURN_CYC = max(1, ceil(tHZ)). With a 5 ns clock and the 55 ns grade this gives 11, 8, 11 and 4.
- R10: `mem_dq_drv` and a low `mem_rd_n` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| busy | output | 1 | Access or turnaround in progress |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_sel | output | 1 | Chip select, active high |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_rd_n | output | 1 | Output enable, active low |
| mem_lo_n | output | 1 | Lower byte strobe, active low |
| mem_hi_n | output | 1 | Upper byte strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_drv | output | 1 | Drive enable for the data bus |

## Verification
The bench runs full-word writes and reads, and single-lane reads of a word that has distinct upper and lower bytes. This shows whether the lane masking picks the correct half and zeroes the other half while the model drives garbage on it. Partial writes over existing data show whether only the enabled lane changes. No-op writes and reads separate a true no-op from an access that is merely short, because memory is read back unchanged afterwards. A request held during `busy` and a reset in the middle of a write show whether acceptance and reset override the sequencing.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the static RAM controller.
// Assumes all timing inputs are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_GAP  = 3'd3,
        ST_NOP  = 3'd4
    } seq_state_t;

    // Ceiling of num/den for converting a time limit into whole clock cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
// Access sequencer: tracks which phase the controller is in and how many
// cycles of that phase have elapsed. It takes a request only when idle.
// Assumes RD_CYC >= 2, WR_CYC >= 2 and TURN_CYC >= 1.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 6,
    parameter int WR_CYC   = 6,
    parameter int TURN_CYC = 2,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_be,
    output seq_state_t       st,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             rd_last,
    output logic             busy
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

    // Acceptance and phase-end decodes used by the other pieces.
    always_comb begin
        accept  = (st == ST_IDLE) && req_valid;
        rd_last = (st == ST_RD) && (cnt == RD_LAST);
        busy    = (st != ST_IDLE);
    end

    // Phase state and phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid) begin
                        if (req_be == 2'b00) st <= ST_NOP;
                        else if (req_write)  st <= ST_WR;
                        else                 st <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (cnt == RD_LAST) begin
                        st  <= ST_GAP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WR: begin
                    if (cnt == WR_LAST) begin
                        st  <= ST_GAP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == TURN_LAST) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    // R7: the end of every access leads into the turnaround gap.
    a_r7_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD && cnt == RD_LAST) |=> (st == ST_GAP));
    a_r7_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR && cnt == WR_LAST) |=> (st == ST_GAP));
    // R8: a no-op occupies exactly one cycle.
    a_r8_noop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NOP) |=> (st == ST_IDLE));
    // R2: a busy sequencer never restarts an access.
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |=> (st == ST_GAP || st == ST_IDLE));

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
// Pin driver: holds every memory-side control, address and data output in a
// register and moves it on the phase edges chosen by the sequencer.
// Assumes WP_CYC + 1 <= WR_CYC so the write strobe ends inside the cycle.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int RD_CYC = 6,
    parameter int WR_CYC = 6,
    parameter int WP_CYC = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        st,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drv
);

    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] WP_END  = CNT_W'(WP_CYC);

    logic start_access;

    // A real access starts only when at least one lane is enabled.
    always_comb start_access = accept && (req_be != 2'b00);

    // Registered pin sequencing for select, strobes, address and data bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n  <= 1'b1;
            mem_sel    <= 1'b0;
            mem_wr_n   <= 1'b1;
            mem_rd_n   <= 1'b1;
            mem_lo_n   <= 1'b1;
            mem_hi_n   <= 1'b1;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_dq_drv <= 1'b0;
        end else begin
            if (start_access) begin
                mem_addr  <= req_addr;
                mem_sel_n <= 1'b0;
                mem_sel   <= 1'b1;
                mem_lo_n  <= ~req_be[0];
                mem_hi_n  <= ~req_be[1];
                if (req_write) begin
                    mem_dq_out <= req_wdata;
                    mem_dq_drv <= 1'b1;
                end
            end
            case (st)
                ST_RD: begin
                    if (cnt == '0) mem_rd_n <= 1'b0;
                    if (cnt == RD_LAST) begin
                        mem_rd_n  <= 1'b1;
                        mem_sel_n <= 1'b1;
                        mem_sel   <= 1'b0;
                        mem_lo_n  <= 1'b1;
                        mem_hi_n  <= 1'b1;
                    end
                end
                ST_WR: begin
                    if (cnt == '0)    mem_wr_n <= 1'b0;
                    if (cnt == WP_END) mem_wr_n <= 1'b1;
                    if (cnt == WR_LAST) begin
                        mem_wr_n   <= 1'b1;
                        mem_sel_n  <= 1'b1;
                        mem_sel    <= 1'b0;
                        mem_lo_n   <= 1'b1;
                        mem_hi_n   <= 1'b1;
                        mem_dq_drv <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: output enable stays high whenever the write strobe is low.
    a_r5_rd_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_rd_n);
    // R5: data is driven and the chip selected through the whole write pulse.
    a_r5_data_under_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_dq_drv && !mem_sel_n && mem_sel));
    // R10: the controller never drives while the memory may drive.
    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drv |-> mem_rd_n);
    // R3: output enable is only ever low inside a selected, strobed read.
    a_r3_rd_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_sel_n && mem_sel && !(mem_lo_n && mem_hi_n)));
    // R6: data stays stable while the write strobe is low.
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && !$past(mem_wr_n)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/sram_ctrl_rdcap.sv
`timescale 1ns/1ps
// Read capture: samples the memory data bus on the last read cycle and
// zeroes the lanes whose byte strobe was inactive. Assumes two byte lanes.
module sram_ctrl_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_last,
    input  logic              mem_lo_n,
    input  logic              mem_hi_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int LANE_W = DATA_W / 2;

    logic [1:0]        lane_on;
    logic [DATA_W-1:0] masked;

    // Active lanes, low lane first.
    always_comb lane_on = {~mem_hi_n, ~mem_lo_n};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_lane
            // Pass a lane only when its strobe is active.
            assign masked[g*LANE_W +: LANE_W] =
                lane_on[g] ? mem_dq_in[g*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    // Capture register and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_last;
            if (rd_last) rsp_data <= masked;
        end
    end

    // R4: the valid indication is a single-cycle pulse.
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Top level of the asynchronous static RAM controller. Converts the
// nanosecond limits of a speed grade into cycle counts and wires the
// sequencer, pin driver and read capture together. Assumes CLK_NS > 0.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 25,
    parameter int T_WC_NS = 55,
    parameter int T_WP_NS = 40,
    parameter int T_CW_NS = 45,
    parameter int T_DW_NS = 25,
    parameter int T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_drv
);

    // R9: phase lengths from ceiling division of the time limits.
    localparam int RD_CYC   = max2(max2(ceil_div(T_RC_NS, CLK_NS), ceil_div(T_AA_NS, CLK_NS)),
                                   1 + ceil_div(T_OE_NS, CLK_NS));
    localparam int WP_CYC   = max2(ceil_div(T_WP_NS, CLK_NS),
                                   max2(ceil_div(T_CW_NS, CLK_NS) - 1, ceil_div(T_DW_NS, CLK_NS) - 1));
    localparam int WR_CYC   = max2(ceil_div(T_WC_NS, CLK_NS), WP_CYC + 1);
    localparam int TURN_CYC = max2(1, ceil_div(T_HZ_NS, CLK_NS));
    localparam int CNT_W    = $clog2(max2(max2(RD_CYC, WR_CYC), TURN_CYC) + 1);

    seq_state_t       seq_st;
    logic [CNT_W-1:0] seq_cnt;
    logic             seq_accept;
    logic             seq_rd_last;

    sram_ctrl_seq #(
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .TURN_CYC(TURN_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_be   (req_be),
        .st       (seq_st),
        .cnt      (seq_cnt),
        .accept   (seq_accept),
        .rd_last  (seq_rd_last),
        .busy     (busy)
    );

    sram_ctrl_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .RD_CYC(RD_CYC),
        .WR_CYC(WR_CYC),
        .WP_CYC(WP_CYC),
        .CNT_W (CNT_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (seq_st),
        .cnt       (seq_cnt),
        .accept    (seq_accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_wr_n  (mem_wr_n),
        .mem_rd_n  (mem_rd_n),
        .mem_lo_n  (mem_lo_n),
        .mem_hi_n  (mem_hi_n),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .mem_dq_drv(mem_dq_drv)
    );

    sram_ctrl_rdcap #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_last  (seq_rd_last),
        .mem_lo_n (mem_lo_n),
        .mem_hi_n (mem_hi_n),
        .mem_dq_in(mem_dq_in),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    // R1: an idle controller leaves every memory pin inactive.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_drv));
    // R7: during the turnaround gap the bus is released and nothing is selected.
    a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_GAP) |-> (mem_sel_n && mem_rd_n && mem_wr_n && !mem_dq_drv));
    // R8: a no-op never raises a response.
    a_r8_noop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_NOP) |=> !rsp_valid);

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, no-ops and requests presented while busy.
module sram_async_ctrl_bench;

    // R9: expected cycle counts for a 5 ns clock and the 55 ns grade.
    localparam int RD = 11;
    localparam int WP = 8;
    localparam int WR = 11;
    localparam int TURN = 4;
    localparam int NVEC = 14;

    // Vector: [38] write, [37:34] address, [33:18] data, [17:16] be, [15:0] expected read.
    localparam logic [38:0] VEC [0:NVEC-1] = '{
        {1'b1, 4'h1, 16'h1234, 2'b11, 16'h0000},
        {1'b1, 4'h2, 16'hABCD, 2'b11, 16'h0000},
        {1'b0, 4'h1, 16'h0000, 2'b11, 16'h1234},
        {1'b0, 4'h2, 16'h0000, 2'b01, 16'h00CD},
        {1'b0, 4'h2, 16'h0000, 2'b10, 16'hAB00},
        {1'b1, 4'h1, 16'h5678, 2'b01, 16'h0000},
        {1'b0, 4'h1, 16'h0000, 2'b11, 16'h1278},
        {1'b1, 4'h2, 16'h9900, 2'b10, 16'h0000},
        {1'b0, 4'h2, 16'h0000, 2'b11, 16'h99CD},
        {1'b1, 4'h3, 16'hFFFF, 2'b11, 16'h0000},
        {1'b0, 4'h3, 16'h0000, 2'b11, 16'hFFFF},
        {1'b1, 4'h3, 16'h0000, 2'b00, 16'h0000},
        {1'b0, 4'h3, 16'h0000, 2'b11, 16'hFFFF},
        {1'b0, 4'h1, 16'h0000, 2'b00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        busy, rsp_valid;
    logic [15:0] rsp_data;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n;
    logic [18:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic        mem_dq_drv;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.CLK_NS(5)) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_drv(mem_dq_drv)
    );

    // Memory model: 16 words, lane writes while write enable is low,
    // garbage on lanes whose strobe is inactive during a read.
    logic [15:0] mem [0:15];
    logic        sel_on;
    assign sel_on = !mem_sel_n && mem_sel;
    assign mem_dq_in = (sel_on && mem_wr_n && !mem_rd_n) ?
        {mem_hi_n ? 8'hEE : mem[mem_addr[3:0]][15:8],
         mem_lo_n ? 8'hEE : mem[mem_addr[3:0]][7:0]} : 16'h5A5A;

    always @(posedge clk) begin
        if (sel_on && !mem_wr_n) begin
            if (!mem_lo_n) mem[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_hi_n) mem[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and follow its cycles, comparing pins with the timeline.
    task automatic do_op(input bit wr, input logic [3:0] a, input logic [15:0] d,
                         input logic [1:0] be, input logic [15:0] exp);
        bit noop = (be == 2'b00);
        int acc = noop ? 0 : (wr ? WR : RD);
        int bad_sel = 0, bad_rd = 0, bad_wr = 0, bad_drv = 0, bad_busy = 0, bad_val = 0, bad_lane = 0;
        logic [15:0] got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {15'd0, a}; req_wdata = d; req_be = be;
        @(posedge clk);
        for (int n = 0; n <= acc + TURN; n++) begin
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            if (noop) begin
                if (busy != (n == 0)) bad_busy++;
                if (!mem_sel_n || !mem_wr_n || !mem_rd_n) bad_sel++;
                if (rsp_valid) bad_val++;
            end else begin
                if ((!mem_sel_n && mem_sel) != (n < acc)) bad_sel++;
                if (n < acc && (mem_lo_n != ~be[0] || mem_hi_n != ~be[1])) bad_lane++;
                if (busy != (n < acc + TURN)) bad_busy++;
                if ((!mem_rd_n) != (!wr && n >= 1 && n < acc)) bad_rd++;
                if ((!mem_wr_n) != (wr && n >= 1 && n <= WP)) bad_wr++;
                if (mem_dq_drv != (wr && n < acc)) bad_drv++;
                if (wr && n < acc && mem_dq_out != d) bad_drv++;
                if (rsp_valid != (!wr && n == acc)) bad_val++;
                if (!wr && n == acc) got = rsp_data;
            end
        end
        if (noop) begin
            chk(bad_busy == 0 && bad_sel == 0 && bad_val == 0, "R8 no-op pins/busy", bad_sel + bad_busy, 0);
        end else begin
            chk(bad_sel == 0, "R3/R5 select window", bad_sel, 0);
            chk(bad_lane == 0, "R6 byte strobes", bad_lane, 0);
            chk(bad_busy == 0, "R7 turnaround busy", bad_busy, 0);
            if (wr) begin
                chk(bad_wr == 0 && bad_rd == 0, "R5 write pulse", bad_wr + bad_rd, 0);
                chk(bad_drv == 0, "R5 data drive", bad_drv, 0);
            end else begin
                chk(bad_rd == 0 && bad_wr == 0 && bad_drv == 0, "R3 read strobes", bad_rd + bad_wr + bad_drv, 0);
                chk(bad_val == 0, "R4 valid pulse", bad_val, 0);
                chk(got == exp, "R4 read data", got, exp);
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && mem_lo_n && mem_hi_n
            && !mem_dq_drv && !busy && !rsp_valid, "R1 reset state", {busy, mem_sel_n, mem_dq_drv}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk covering R3, R4, R5, R6, R7, R8 and R9 timings.
        for (int v = 0; v < NVEC; v++)
            do_op(VEC[v][38], VEC[v][37:34], VEC[v][33:18], VEC[v][17:16], VEC[v][15:0]);

        // R2: a request held while busy is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'd4; req_wdata = 16'h4444; req_be = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_wdata = 16'h7777; req_addr = 19'd5;
        repeat (3) @(negedge clk);
        chk(mem_dq_out == 16'h4444 && mem_addr == 19'd4, "R2 pins held while busy", mem_dq_out, 16'h4444);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        do_op(1'b0, 4'h4, 16'h0, 2'b11, 16'h4444);
        do_op(1'b0, 4'h5, 16'h0, 2'b11, 16'h0000);

        // R1: reset in the middle of a write returns pins to inactive.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'd6; req_wdata = 16'h6666; req_be = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_drv && !busy,
            "R1 reset mid-write", {mem_wr_n, mem_dq_drv, busy}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset accepts a fresh read of the full word.
        do_op(1'b0, 4'h2, 16'h0, 2'b11, 16'h99CD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule